// File: doc/BRIEF.md
# Supervisory Reset Sequencer

This block decides when a processor is held in reset. It combines three reset causes: a supply-good flag from an external analog comparator, an active-low pushbutton, and a one-cycle expiry request from a separate watchdog counter. The result drives a pair of complementary reset outputs and a status flag. Each hold period is timed by a millisecond tick strobe, so every duration is a whole number of ticks.

A mode input selects between two processor styles. In NMOS mode, reset stays on for as long as the supply is bad. In CMOS mode, the processor is battery backed, so a falling supply never causes a power-down reset. A power-on hold is still applied in both modes when the supply comes back.

The pushbutton is synchronised and then debounced. Its hold period starts only when the release is accepted. The button is disregarded when the battery is dominant. In CMOS mode it is also disregarded while the early-warning level is low. Any new cause during an ongoing hold restarts the hold at its full length.

Top module: `sup_reset_seq`

## Requirements
- R1: In NMOS mode (`cmos_mode`=0), `rst_out` is 1 from the cycle after `supply_ok` is seen at 0, and it stays 1 while `supply_ok` is 0.
- R2: After `supply_ok` rises, `rst_out` stays 1 for exactly `HOLD_TICKS` tick strobes and then drops. It drops only on a tick.
- R3: While `arst_n` is 0, and directly after it is released, `rst_out` is 1 and `rst_out_n` is 0.
- R4: `pb_n` is passed through two flops. A change is accepted once the synchronised level has differed from the accepted level for `DEB_TICKS` ticks. An accepted press holds `rst_out` at 1 for as long as the button stays pressed. From the first tick of the stable release, reset lasts `DEB_TICKS`+`HOLD_TICKS` ticks.
- R5: A pushbutton low pulse that spans fewer than `DEB_TICKS` ticks once synchronised leaves `rst_out` at 0.
- R6: While `batt_dom` is 1, the pushbutton has no effect on `rst_out`, whether it is pressed or released.
- R7: While `cmos_mode`=1 and `early_low`=1, the pushbutton has no effect. In NMOS mode, `early_low` does not gate the pushbutton.
- R8: A one-cycle `wdt_expire` pulse sets `rst_out` to 1 on the next cycle, in either mode, and reset lasts `HOLD_TICKS` ticks.
- R9: In CMOS mode, a falling `supply_ok` leaves `rst_out` at 0. A later rise of `supply_ok` starts a full `HOLD_TICKS` hold.
- R10: A new cause during an active hold reloads the hold to its full `HOLD_TICKS` length.
- R11: `rst_out_n` is always the inverse of `rst_out`. `rst_busy` equals `rst_out`, so a watchdog can start timing only after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle millisecond strobe |
| supply_ok | input | 1 | Main supply within tolerance |
| pb_n | input | 1 | Pushbutton, active low, asynchronous |
| wdt_expire | input | 1 | Watchdog expiry request |
| cmos_mode | input | 1 | 1 = CMOS (no power-down reset), 0 = NMOS |
| batt_dom | input | 1 | Main supply below battery level |
| early_low | input | 1 | Early-warning level below its trip point |
| rst_out | output | 1 | Reset, active high |
| rst_out_n | output | 1 | Reset, active low |
| rst_busy | output | 1 | Reset in progress, for the watchdog |

## Verification
The hardest case to reach is the exact length of a pushbutton-released reset. That count passes through two synchroniser stages, the debounce counter, a one-cycle release reload, and the hold countdown, and each of these counts ticks rather than cycles. The bench fixes the tick phase before every stimulus change, so that no tick falls in the synchroniser cycles. It can then predict the exact number of ticks until reset is released. The gating of the pushbutton is swept over all eight combinations of mode, battery-dominant and early-warning flags.

// File: rtl/sup_reset_seq.sv
module sup_reset_seq #(
  parameter int HOLD_TICKS = 100,
  parameter int DEB_TICKS  = 20
) (
  input  logic clk,
  input  logic arst_n,
  input  logic tick,
  input  logic supply_ok,
  input  logic pb_n,
  input  logic wdt_expire,
  input  logic cmos_mode,
  input  logic batt_dom,
  input  logic early_low,
  output logic rst_out,
  output logic rst_out_n,
  output logic rst_busy
);
  localparam int HW = $clog2(HOLD_TICKS + 1);
  localparam int DW = $clog2(DEB_TICKS + 1);

  logic [1:0]    pb_sync;
  logic          pb_level;
  logic [DW-1:0] deb_cnt;
  logic          pb_held;
  logic          sup_prev;
  logic [HW-1:0] hold_cnt;

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) pb_sync <= 2'b11;
    else         pb_sync <= {pb_sync[0], pb_n};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      pb_level <= 1'b1;
      deb_cnt  <= '0;
    end else if (pb_sync[1] == pb_level) begin
      deb_cnt <= '0;
    end else if (tick) begin
      if (deb_cnt == DW'(DEB_TICKS - 1)) begin
        pb_level <= pb_sync[1];
        deb_cnt  <= '0;
      end else begin
        deb_cnt <= deb_cnt + 1'b1;
      end
    end
  end

  logic pb_allowed, pb_press, pb_release, sup_rise, nmos_low, reload;
  assign pb_allowed = !batt_dom && !(cmos_mode && early_low);
  assign pb_press   = !pb_level && pb_allowed;
  assign pb_release = pb_held && !pb_press;
  assign sup_rise   = supply_ok && !sup_prev;
  assign nmos_low   = !cmos_mode && !supply_ok;
  assign reload     = nmos_low || sup_rise || wdt_expire || pb_press || pb_release;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      pb_held  <= 1'b0;
      sup_prev <= 1'b0;
      hold_cnt <= HW'(HOLD_TICKS);
    end else begin
      pb_held  <= pb_press;
      sup_prev <= supply_ok;
      if (reload)
        hold_cnt <= HW'(HOLD_TICKS);
      else if (tick && hold_cnt != '0)
        hold_cnt <= hold_cnt - 1'b1;
    end
  end

  assign rst_out   = (hold_cnt != '0);
  assign rst_out_n = !rst_out;
  assign rst_busy  = rst_out;
endmodule

// File: rtl/sup_reset_seq_chk.sv
module sup_reset_seq_chk #(
  parameter int HOLD_TICKS = 100,
  parameter int HW = 7
) (
  input logic          clk,
  input logic          arst_n,
  input logic          tick,
  input logic          supply_ok,
  input logic          cmos_mode,
  input logic          batt_dom,
  input logic          wdt_expire,
  input logic          rst_out,
  input logic [HW-1:0] hold_cnt
);
  assert_nmos_low_R1: assert property (@(posedge clk) disable iff (!arst_n)
    (!cmos_mode && !supply_ok) |=> rst_out);

  assert_tick_release_R2: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(rst_out) |-> $past(tick));

  assert_wdt_assert_R8: assert property (@(posedge clk) disable iff (!arst_n)
    wdt_expire |=> rst_out);

  assert_full_reload_R10: assert property (@(posedge clk) disable iff (!arst_n)
    wdt_expire |=> (hold_cnt == HW'(HOLD_TICKS)));

  assert_batt_gate_R6: assert property (@(posedge clk) disable iff (!arst_n)
    (batt_dom && $past(batt_dom) && !rst_out && !wdt_expire &&
     supply_ok && $past(supply_ok)) |=> !rst_out);
endmodule

bind sup_reset_seq sup_reset_seq_chk #(.HOLD_TICKS(HOLD_TICKS), .HW(HW)) u_chk (
  .clk(clk), .arst_n(arst_n), .tick(tick), .supply_ok(supply_ok),
  .cmos_mode(cmos_mode), .batt_dom(batt_dom), .wdt_expire(wdt_expire),
  .rst_out(rst_out), .hold_cnt(hold_cnt)
);

// File: tb/sup_reset_seq_bench.sv
module sup_reset_seq_bench;
  localparam int HOLD = 5;
  localparam int DEB  = 3;

  logic clk = 0;
  logic arst_n = 0;
  logic supply_ok = 0, pb_n = 1, wdt_expire = 0;
  logic cmos_mode = 0, batt_dom = 0, early_low = 0;
  logic rst_out, rst_out_n, rst_busy;
  logic [1:0] tcnt = 0;
  logic tick;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;
  always @(posedge clk) tcnt <= tcnt + 1'b1;
  assign tick = (tcnt == 2'd3);

  sup_reset_seq #(.HOLD_TICKS(HOLD), .DEB_TICKS(DEB)) u_sup_reset_seq (
    .clk(clk), .arst_n(arst_n), .tick(tick), .supply_ok(supply_ok), .pb_n(pb_n),
    .wdt_expire(wdt_expire), .cmos_mode(cmos_mode), .batt_dom(batt_dom),
    .early_low(early_low), .rst_out(rst_out), .rst_out_n(rst_out_n), .rst_busy(rst_busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
    checks++;
    if (rst_out_n !== !rst_out || rst_busy !== rst_out) begin
      errors++;
      $display("FAIL R11 actual n=%0b busy=%0b expected n=%0b busy=%0b",
               rst_out_n, rst_busy, !rst_out, rst_out);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic align();
    @(negedge clk);
    while (!tick) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic measure(output int n);
    n = 0;
    for (int i = 0; i < 600; i++) begin
      if (!rst_out) break;
      if (tick) n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 600; i++) begin
      if (!rst_out) break;
      @(negedge clk);
    end
  endtask

  task automatic run();
    int n;
    cyc(3);
    chk("R3 reset held", rst_out, 1);
    arst_n = 1;
    cyc(10);
    chk("R3 after release", rst_out, 1);
    chk("R1 nmos supply low", rst_out, 1);
    align(); supply_ok = 1; @(negedge clk);
    measure(n);
    chk("R2 power-on hold ticks", n, HOLD);

    cyc(3); supply_ok = 0; @(negedge clk);
    chk("R1 next cycle", rst_out, 1);
    cyc(25);
    chk("R1 stays", rst_out, 1);
    align(); supply_ok = 1; @(negedge clk);
    measure(n);
    chk("R2 hold after dip", n, HOLD);

    cmos_mode = 1; cyc(3); supply_ok = 0; cyc(30);
    chk("R9 no power-down reset", rst_out, 0);
    align(); supply_ok = 1; @(negedge clk);
    chk("R9 power-on asserted", rst_out, 1);
    measure(n);
    chk("R9 power-on hold ticks", n, HOLD);

    for (int m = 0; m < 2; m++) begin
      cmos_mode = m[0]; cyc(3);
      align(); wdt_expire = 1; @(negedge clk); wdt_expire = 0;
      chk("R8 wdt asserts", rst_out, 1);
      measure(n);
      chk("R8 wdt hold ticks", n, HOLD);
      cyc(3);
      align(); wdt_expire = 1; @(negedge clk); wdt_expire = 0;
      cyc(10);
      chk("R10 mid-hold", rst_out, 1);
      align(); wdt_expire = 1; @(negedge clk); wdt_expire = 0;
      measure(n);
      chk("R10 reload full", n, HOLD);
    end

    for (int c = 0; c < 8; c++) begin
      logic exp_on;
      string tag;
      cmos_mode = c[0]; batt_dom = c[1]; early_low = c[2];
      exp_on = !batt_dom && !(cmos_mode && early_low);
      tag = batt_dom ? "R6" : (early_low ? "R7" : "R4");
      cyc(3);
      align(); pb_n = 0; cyc(60);
      chk({tag, " press level"}, rst_out, exp_on);
      align(); pb_n = 1;
      if (exp_on) begin
        measure(n);
        chk({tag, " release ticks"}, n, DEB + HOLD);
      end else begin
        cyc(60);
        chk({tag, " release ignored"}, rst_out, 0);
      end
      batt_dom = 0; early_low = 0; cyc(3); wait_idle();
    end

    cmos_mode = 0; cyc(3);
    align(); pb_n = 0; cyc(8); pb_n = 1; cyc(60);
    chk("R5 short pulse", rst_out, 0);
    align(); pb_n = 0; cyc(12); pb_n = 1; cyc(2);
    chk("R5 long pulse accepted", rst_out, 1);
    wait_idle();
  endtask

  initial begin
    fork
      run();
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R2 actual timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule